// File: doc/BRIEF.md
# Device Address Window Decode with Vectored Interrupts

This block sits between a processor I/O channel and a group of customer devices. Each channel command carries a 4-bit device address, a function code and a modifier. The block decides whether that address falls inside a window of 4, 8 or 16 contiguous addresses chosen by configuration straps. A command that hits the window produces a one-cycle device select and an acknowledge. A command that misses produces nothing.

The block also gathers up to 16 interrupt request lines, one for each address in the window. It presents one interrupt to the processor. That interrupt carries the address of the requesting device and a level number that all devices share. The level and a shared enable bit live in a prepare register, which a dedicated command writes. A pair of straps can mask all interrupts while the block runs in external diagnostic mode.

Top module: `devwin_irq_top`

## Requirements
- R1: `cfg_size` selects the window size: 0 gives 4 addresses, 1 gives 8, and 2 or 3 give 16. An address hits when its bits above the low 2, 3 or 4 bits equal those of `cfg_base`. The low bits of `cfg_base` are ignored, so the window is always aligned to its size.
- R2: A command that hits the window with a function code other than 7 raises `dev_sel` and `cmd_ack` in the cycle after `cmd_valid`, for exactly one cycle. In that same cycle `sel_func`, `sel_mod` and `sel_addr` hold the command's fields.
- R3: A command that misses the window raises neither `dev_sel` nor `cmd_ack`. A prepare command that misses the window leaves the prepare register unchanged.
- R4: A prepare command (function code 7) that hits the window loads the level from `cmd_wdata[LVL_W-1:0]` and the enable bit from `cmd_wdata[WORD_W-1]`. It raises `cmd_ack` one cycle later and does not raise `dev_sel`.
- R5: Request line i belongs to window offset i. A line is latched as pending on a clock edge while it is high. Lines whose offset is at or beyond the window size are ignored.
- R6: While any request is pending and the gate is open, `irq_out` is high. `irq_addr` then equals the aligned base plus the lowest pending offset, and `irq_level` holds the prepared level.
- R7: `irq_ack` while `irq_out` is high clears the presented request. From the next cycle the next-lowest pending request is presented, and `irq_out` drops if no request is left.
- R8: When the prepare enable bit is clear, `irq_out` stays low, but pending requests are kept. They are presented again once the enable bit is set.
- R9: When `cfg_diag_ext` and `cfg_diag_mask` are both high, `irq_out` stays low. `cfg_diag_ext` alone does not mask interrupts.
- R10: After reset `dev_sel`, `cmd_ack` and `irq_out` are low, and the prepare register is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Window size strap |
| cfg_base | input | 4 | Window base strap |
| cfg_diag_ext | input | 1 | External diagnostic mode |
| cfg_diag_mask | input | 1 | Mask interrupts in external diagnostic mode |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_func | input | FUNC_W | Function code |
| cmd_mod | input | MOD_W | Modifier |
| cmd_addr | input | 4 | Device address |
| cmd_wdata | input | WORD_W | Command data word (prepare payload) |
| dev_sel | output | 1 | One-cycle device select |
| sel_func | output | FUNC_W | Function of the selected command |
| sel_mod | output | MOD_W | Modifier of the selected command |
| sel_addr | output | 4 | Address of the selected command |
| cmd_ack | output | 1 | Acknowledge for an in-window command |
| irq_req | input | 16 | Request lines, one per window offset |
| irq_ack | input | 1 | Processor interrupt acknowledge |
| irq_out | output | 1 | Vectored interrupt request |
| irq_level | output | LVL_W | Shared interrupt level |
| irq_addr | output | 4 | Address of the presented device |

## Verification
The assertions check on every cycle that a select or an acknowledge follows only an in-window command. They also check that the interrupt is never raised while the enable bit is clear or the diagnostic mask is active, that the presented address lies inside the window, and that at most one pending request is granted. Only the bench scenarios can show the other behaviours. These include the exact hit and miss boundaries for each window size, the one-cycle width of the select, and the payload taken by the prepare command. They also include lowest-first ordering across acknowledges, and pending requests surviving a disable or mask period and reappearing afterwards.

// File: rtl/devwin_pkg.sv
package devwin_pkg;
  localparam int ADDR_W = 4;
  localparam int NSRC   = 1 << ADDR_W;

  // low address bits ignored by the window: 2, 3 or 4 of them
  function automatic logic [ADDR_W-1:0] low_mask(input logic [1:0] sz);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int b = 0; b < ADDR_W; b++)
      if (b < 2 + int'(sz)) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input logic [1:0] sz);
    return ((a ^ base) & ~low_mask(sz)) == '0;
  endfunction

  // request lines that fall inside the window
  function automatic logic [NSRC-1:0] line_enables(input logic [1:0] sz);
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i++)
      v[i] = (ADDR_W'(i) & ~low_mask(sz)) == '0;
    return v;
  endfunction

  function automatic logic [ADDR_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [ADDR_W-1:0] idx;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) idx = ADDR_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/devwin_decode.sv
module devwin_decode
  import devwin_pkg::*;
#(
  parameter int FUNC_W = 3,
  parameter int MOD_W  = 4,
  parameter logic [FUNC_W-1:0] PREP_FN = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [MOD_W-1:0]  cmd_mod,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [1:0]        cfg_size,
  output logic              hit,
  output logic              prep_wr,
  output logic              dev_sel,
  output logic              cmd_ack,
  output logic [FUNC_W-1:0] sel_func,
  output logic [MOD_W-1:0]  sel_mod,
  output logic [ADDR_W-1:0] sel_addr
);
  logic is_prep;
  logic sel_next;

  always_comb begin
    hit      = cmd_valid && addr_hit(cmd_addr, cfg_base, cfg_size);
    is_prep  = (cmd_func == PREP_FN);
    prep_wr  = hit && is_prep;
    sel_next = hit && !is_prep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_sel  <= 1'b0;
      cmd_ack  <= 1'b0;
      sel_func <= '0;
      sel_mod  <= '0;
      sel_addr <= '0;
    end else begin
      dev_sel <= sel_next;
      cmd_ack <= hit;
      if (sel_next) begin
        sel_func <= cmd_func;
        sel_mod  <= cmd_mod;
        sel_addr <= cmd_addr;
      end
    end
  end
endmodule

// File: rtl/devwin_prep.sv
module devwin_prep #(
  parameter int WORD_W = 16,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prep_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [LVL_W-1:0]  level,
  output logic              enable
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      enable <= 1'b0;
    end else if (prep_wr) begin
      level  <= wdata[LVL_W-1:0];
      enable <= wdata[WORD_W-1];
    end
  end
endmodule

// File: rtl/devwin_vector.sv
module devwin_vector
  import devwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic [NSRC-1:0]   line_en,
  input  logic              gate,
  input  logic              irq_ack,
  output logic [NSRC-1:0]   grant,
  output logic              irq_out,
  output logic [ADDR_W-1:0] irq_off
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] clr;

  always_comb begin
    grant   = pend & (~pend + NSRC'(1));
    irq_off = first_set(pend);
    irq_out = gate && (|pend);
    clr     = (irq_ack && irq_out) ? grant : '0;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[g] <= 1'b0;
      else        pend[g] <= (pend[g] | irq_req[g]) & line_en[g] & ~clr[g];
    end
  end
endmodule

// File: rtl/devwin_irq_top.sv
module devwin_irq_top
  import devwin_pkg::*;
#(
  parameter int FUNC_W = 3,
  parameter int MOD_W  = 4,
  parameter int WORD_W = 16,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_diag_ext,
  input  logic              cfg_diag_mask,
  input  logic              cmd_valid,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [MOD_W-1:0]  cmd_mod,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              dev_sel,
  output logic [FUNC_W-1:0] sel_func,
  output logic [MOD_W-1:0]  sel_mod,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              cmd_ack,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              irq_ack,
  output logic              irq_out,
  output logic [LVL_W-1:0]  irq_level,
  output logic [ADDR_W-1:0] irq_addr
);
  localparam logic [FUNC_W-1:0] PREP_FN = '1;

  // named internal events for the checker
  logic              cmd_hit;
  logic              prep_wr;
  logic              prep_en;
  logic              diag_block;
  logic              irq_gate;
  logic [NSRC-1:0]   grant;
  logic [ADDR_W-1:0] irq_off;
  logic [NSRC-1:0]   line_en;

  always_comb begin
    diag_block = cfg_diag_ext && cfg_diag_mask;
    irq_gate   = prep_en && !diag_block;
    line_en    = line_enables(cfg_size);
    irq_addr   = (cfg_base & ~low_mask(cfg_size)) | irq_off;
  end

  devwin_decode #(.FUNC_W(FUNC_W), .MOD_W(MOD_W), .PREP_FN(PREP_FN)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .cmd_mod(cmd_mod), .cmd_addr(cmd_addr), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .hit(cmd_hit), .prep_wr(prep_wr),
    .dev_sel(dev_sel), .cmd_ack(cmd_ack), .sel_func(sel_func),
    .sel_mod(sel_mod), .sel_addr(sel_addr)
  );

  devwin_prep #(.WORD_W(WORD_W), .LVL_W(LVL_W)) u_prep (
    .clk(clk), .rst_n(rst_n), .prep_wr(prep_wr), .wdata(cmd_wdata),
    .level(irq_level), .enable(prep_en)
  );

  devwin_vector u_vec (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .line_en(line_en),
    .gate(irq_gate), .irq_ack(irq_ack), .grant(grant),
    .irq_out(irq_out), .irq_off(irq_off)
  );
endmodule

// File: rtl/devwin_irq_chk.sv
module devwin_irq_chk
  import devwin_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_hit,
  input logic              dev_sel,
  input logic              cmd_ack,
  input logic              irq_out,
  input logic [ADDR_W-1:0] irq_addr,
  input logic              prep_en,
  input logic              diag_block,
  input logic [NSRC-1:0]   grant,
  input logic [ADDR_W-1:0] cfg_base,
  input logic [1:0]        cfg_size
);
  // R2
  sel_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel |-> $past(cmd_valid && cmd_hit));

  // R3
  ack_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> $past(cmd_valid && cmd_hit));

  // R2
  sel_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel |-> cmd_ack);

  // R8
  irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> prep_en);

  // R9
  irq_diag_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> !diag_block);

  // R6
  irq_addr_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> addr_hit(irq_addr, cfg_base, cfg_size));

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind devwin_irq_top devwin_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_hit(cmd_hit),
  .dev_sel(dev_sel), .cmd_ack(cmd_ack), .irq_out(irq_out),
  .irq_addr(irq_addr), .prep_en(prep_en), .diag_block(diag_block),
  .grant(grant), .cfg_base(cfg_base), .cfg_size(cfg_size)
);

// File: tb/sim_devwin_irq_top.sv
`timescale 1ns/1ps
module sim_devwin_irq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_size = 2'd0;
  logic [3:0]  cfg_base = 4'd0;
  logic        cfg_diag_ext = 1'b0, cfg_diag_mask = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_func = 3'd0;
  logic [3:0]  cmd_mod = 4'd0, cmd_addr = 4'd0;
  logic [15:0] cmd_wdata = 16'd0;
  logic        dev_sel, cmd_ack, irq_out;
  logic [2:0]  sel_func;
  logic [3:0]  sel_mod, sel_addr, irq_addr;
  logic [15:0] irq_req = 16'd0;
  logic        irq_ack = 1'b0;
  logic [1:0]  irq_level;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  devwin_irq_top u0 (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench's own window rule
  function automatic bit in_win(int a, int base, int sz);
    int ign = (sz >= 2) ? 4 : sz + 2;
    return (a >> ign) == (base >> ign);
  endfunction

  bit s_sel, s_ack;
  logic [2:0] s_func;
  logic [3:0] s_mod, s_addr;

  task automatic send(input logic [2:0] f, input logic [3:0] m,
                      input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f; cmd_mod = m; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    s_sel = dev_sel; s_ack = cmd_ack;
    s_func = sel_func; s_mod = sel_mod; s_addr = sel_addr;
  endtask

  task automatic pulse_req(input logic [15:0] v);
    @(negedge clk); irq_req = v;
    @(negedge clk); irq_req = '0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 dev_sel", dev_sel, 0);
    check("R10 cmd_ack", cmd_ack, 0);
    check("R10 irq_out", irq_out, 0);
    pulse_req(16'h0001);
    check("R10 disabled after reset", irq_out, 0);
    pulse_ack();
  endtask

  task automatic t_window();
    int bases[4] = '{9, 5, 6, 13};
    for (int sz = 0; sz < 4; sz++) begin
      cfg_size = 2'(sz); cfg_base = 4'(bases[sz]);
      for (int a = 0; a < 16; a++) begin
        send(3'd1, 4'(a ^ 4'h5), 4'(a), 16'h0);
        check("R1 hit", s_ack, int'(in_win(a, bases[sz], sz)));
        check(in_win(a, bases[sz], sz) ? "R2 select" : "R3 no select",
              s_sel, int'(in_win(a, bases[sz], sz)));
        if (s_sel) begin
          check("R2 sel_addr", s_addr, a);
          check("R2 sel_mod", s_mod, a ^ 5);
          check("R2 sel_func", s_func, 1);
        end
      end
    end
  endtask

  task automatic t_pulse();
    cfg_size = 2'd1; cfg_base = 4'd8;
    send(3'd2, 4'd3, 4'd12, 16'h0);
    check("R2 select raised", s_sel, 1);
    @(negedge clk);
    check("R2 select one cycle", dev_sel, 0);
    check("R2 ack one cycle", cmd_ack, 0);
  endtask

  task automatic t_prep();
    cfg_size = 2'd0; cfg_base = 4'd8;
    send(3'd7, 4'd0, 4'd2, 16'h8002);
    check("R3 prep miss no ack", s_ack, 0);
    pulse_req(16'h0001);
    check("R3 prep miss leaves disabled", irq_out, 0);
    send(3'd7, 4'd0, 4'd10, 16'h8003);
    check("R4 prep ack", s_ack, 1);
    check("R4 prep no select", s_sel, 0);
    @(negedge clk);
    check("R4 enable loaded", irq_out, 1);
    check("R4 level loaded", irq_level, 3);
    check("R6 address", irq_addr, 8);
    pulse_ack();
    check("R7 cleared", irq_out, 0);
  endtask

  task automatic t_vector();
    cfg_size = 2'd0; cfg_base = 4'd9;
    pulse_req(16'h020A);
    check("R6 lowest first", irq_addr, 9);
    check("R6 irq_out", irq_out, 1);
    pulse_ack();
    check("R7 next request", irq_addr, 11);
    check("R7 still raised", irq_out, 1);
    pulse_ack();
    check("R5 line beyond window ignored", irq_out, 0);
    cfg_size = 2'd2; cfg_base = 4'd7;
    pulse_req(16'h9000);
    check("R6 size 16 lowest", irq_addr, 12);
    pulse_ack();
    check("R7 size 16 next", irq_addr, 15);
    pulse_ack();
    check("R7 empty", irq_out, 0);
  endtask

  task automatic t_disable();
    cfg_size = 2'd1; cfg_base = 4'd0;
    send(3'd7, 4'd0, 4'd1, 16'h0001);
    pulse_req(16'h0020);
    check("R8 disabled holds low", irq_out, 0);
    send(3'd7, 4'd0, 4'd1, 16'h8001);
    @(negedge clk);
    check("R8 pending kept", irq_out, 1);
    check("R8 pending address", irq_addr, 5);
    check("R8 level", irq_level, 1);
    pulse_ack();
  endtask

  task automatic t_diag();
    cfg_size = 2'd0; cfg_base = 4'd4;
    pulse_req(16'h0004);
    cfg_diag_ext = 1'b1; cfg_diag_mask = 1'b0;
    @(negedge clk);
    check("R9 diag alone no mask", irq_out, 1);
    cfg_diag_mask = 1'b1;
    @(negedge clk);
    check("R9 diag masked", irq_out, 0);
    cfg_diag_ext = 1'b0;
    @(negedge clk);
    check("R9 strap alone no mask", irq_out, 1);
    check("R9 address after unmask", irq_addr, 6);
    cfg_diag_mask = 1'b0;
    pulse_ack();
    check("R9 cleared", irq_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_pulse();
    t_prep();
    t_vector();
    t_disable();
    t_diag();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule